// File: doc/BRIEF.md
# Delayed Pulse Train Bank

The block drives eight independent timing outputs. Each output channel waits for an event on one or more of eight trigger source lines, counts off a programmed delay, and then emits a train of pulses. The width and the rise-to-rise spacing of the pulses are programmed, and so is the number of pulses. All times are counted in ticks of a shared time base. A single control input selects a fast tick, the 1 MHz rate, or a tick ten times slower, the 100 kHz rate.

Software sets up a channel indirectly. It first writes the channel number into a pointer register, then writes the settings of that channel through 16-bit data writes. The delay, width and period are 32-bit quantities, each loaded as two 16-bit halves. The repeat count is 16 bits wide and the source mask is 8 bits wide. The channel copies its settings at the moment it starts, so a new setup can be loaded while an earlier train is still running. An active-low inhibit input stops channels from starting, but it does not cut short a train that has already begun.

Top module: `pulse_train_bank`

## Requirements
- R1: While reset is held, and after reset is released, every output is low and no channel is running. All channel settings clear to zero. A channel stopped by reset accepts a new start once it has been reprogrammed.
- R2: Writing address 0 loads a 3-bit channel pointer from wr_data[2:0]. Pointer value k selects pulse_out[k], so value 0 is the first channel and value 7 is the last. Writes to addresses 1 to 8 change only the pointed channel.
- R3: Delay, width and period are 32 bits each. Their low and high halves are written at separate addresses: delay at 1 (low) and 2 (high), width at 3 and 4, period at 5 and 6. The repeat count is at address 7 and the source mask at address 8. A high half takes part in the count, so a delay high half of 1 pushes the first pulse out by 65536 ticks.
- R4: When base_slow is 0, one tick lasts FAST_DIV clock cycles. When base_slow is 1, one tick lasts FAST_DIV*SLOW_RATIO clock cycles.
- R5: An idle channel starts when trig_src shows a rising edge on a source whose bit in the channel's source mask is 1. Edges on sources that are not selected have no effect.
- R6: The first rising edge of the output comes D ticks after the start, where D is the programmed delay and a delay of 0 counts as 1. Measured in clock samples from the trigger cycle, the first rise falls between (D-1)*T+1 and D*T+2, where T is the tick length in cycles.
- R7: Every pulse stays high for exactly W ticks, where W is the programmed width. A channel programmed with width 0 never starts and emits nothing.
- R8: Successive rising edges are P ticks apart when the period P is greater than W. When P is at most W, the low gap between pulses is one tick. The number of pulses equals the repeat count, and a count of 0 or 1 gives a single pulse.
- R9: A trigger that arrives while a channel is running is ignored. The running train keeps its pulse count and its spacing.
- R10: While inhibit_n is low, no idle channel starts. A train that began before inhibit_n went low runs to its end.
- R11: A register write to a channel takes effect at that channel's next start. It does not change a train that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_slow | input | 1 | Time base select: 0 gives the fast tick, 1 gives the slow tick |
| inhibit_n | input | 1 | Active-low inhibit; while low, no channel starts |
| trig_src | input | 8 | Trigger source lines; a channel reacts to rising edges |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address (0 pointer, 1 to 8 per-channel fields) |
| wr_data | input | 16 | Register write data |
| pulse_out | output | 8 | Delayed pulse outputs, bit k belongs to channel k |

## Verification
A table of settings drives distinct channels from distinct sources. It covers delays of 0, 1 and several ticks; periods longer than the width and periods shorter than it; repeat counts of 0, 1 and several; a width of 0; and both time bases. For each entry the first-rise window, the first pulse width, the rise spacing, the pulse count and the silence of every other output are measured, which separates errors in delay, width, gap and count from errors in channel or source routing. Directed runs then send a second trigger during a train, hold inhibit before a start and also assert it during a train, rewrite the width while a train runs, fire a source that the channel does not select, and load a delay high half to show that it lengthens the delay. A final run resets the bank in the middle of a train to confirm the channel returns to idle.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

    localparam int HALF_W = 16;
    localparam int TIME_W = 2 * HALF_W;
    localparam int CNT_W  = 16;
    localparam int NSRC   = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_PTR    = 4'd0;
    localparam logic [ADDR_W-1:0] A_DLY_LO = 4'd1;
    localparam logic [ADDR_W-1:0] A_DLY_HI = 4'd2;
    localparam logic [ADDR_W-1:0] A_WID_LO = 4'd3;
    localparam logic [ADDR_W-1:0] A_WID_HI = 4'd4;
    localparam logic [ADDR_W-1:0] A_PER_LO = 4'd5;
    localparam logic [ADDR_W-1:0] A_PER_HI = 4'd6;
    localparam logic [ADDR_W-1:0] A_REPS   = 4'd7;
    localparam logic [ADDR_W-1:0] A_SRC    = 4'd8;

    typedef struct packed {
        logic [TIME_W-1:0] delay;
        logic [TIME_W-1:0] width;
        logic [TIME_W-1:0] period;
        logic [CNT_W-1:0]  reps;
        logic [NSRC-1:0]   src_sel;
    } ch_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/dpb_tick.sv
module dpb_tick #(
    parameter int FAST_DIV   = 100,
    parameter int SLOW_RATIO = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_i,
    output logic tick_o
);

    localparam int SLOW_DIV = FAST_DIV * SLOW_RATIO;
    localparam int CW       = $clog2(SLOW_DIV + 1);
    localparam logic [CW-1:0] FAST_LIM = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_LIM = CW'(SLOW_DIV - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tick_s_t;

    tick_s_t s_d, s_q;
    logic [CW-1:0] lim;

    initial begin
        if (FAST_DIV < 2) $error("FAST_DIV must be at least 2");
    end

    always_comb begin
        lim = slow_i ? SLOW_LIM : FAST_LIM;
        s_d = s_q;
        if (s_q.cnt >= lim) begin
            s_d.cnt  = '0;
            s_d.tick = 1'b1;
        end else begin
            s_d.cnt  = s_q.cnt + ONE;
            s_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;

    // R4
    tick_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);

endmodule

// File: rtl/dpb_regfile.sv
module dpb_regfile import dpb_pkg::*; #(
    parameter int NUM_CH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en_i,
    input  logic [ADDR_W-1:0]      wr_addr_i,
    input  logic [HALF_W-1:0]      wr_data_i,
    output ch_cfg_t [NUM_CH-1:0]   cfg_o
);

    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    typedef struct packed {
        logic [PTR_W-1:0]      ptr;
        ch_cfg_t [NUM_CH-1:0]  cfg;
    } reg_s_t;

    reg_s_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en_i) begin
            if (wr_addr_i == A_PTR) begin
                s_d.ptr = wr_data_i[PTR_W-1:0];
            end else if (int'(s_q.ptr) < NUM_CH) begin
                case (wr_addr_i)
                    A_DLY_LO: s_d.cfg[s_q.ptr].delay[HALF_W-1:0]       = wr_data_i;
                    A_DLY_HI: s_d.cfg[s_q.ptr].delay[TIME_W-1:HALF_W]  = wr_data_i;
                    A_WID_LO: s_d.cfg[s_q.ptr].width[HALF_W-1:0]       = wr_data_i;
                    A_WID_HI: s_d.cfg[s_q.ptr].width[TIME_W-1:HALF_W]  = wr_data_i;
                    A_PER_LO: s_d.cfg[s_q.ptr].period[HALF_W-1:0]      = wr_data_i;
                    A_PER_HI: s_d.cfg[s_q.ptr].period[TIME_W-1:HALF_W] = wr_data_i;
                    A_REPS:   s_d.cfg[s_q.ptr].reps                    = wr_data_i[CNT_W-1:0];
                    A_SRC:    s_d.cfg[s_q.ptr].src_sel                 = wr_data_i[NSRC-1:0];
                    default:  ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cfg_o = s_q.cfg;

    // R2
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && wr_addr_i == A_PTR) |=> $stable(s_q.ptr));

    // R11
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(cfg_o));

endmodule

// File: rtl/dpb_channel.sv
module dpb_channel import dpb_pkg::*; (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    input  logic            inhibit_n_i,
    input  logic [NSRC-1:0] src_rise_i,
    input  ch_cfg_t         cfg_i,
    output logic            pulse_o
);

    localparam logic [TIME_W-1:0] ONE_T = TIME_W'(1);
    localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);

    typedef struct packed {
        ch_state_e         st;
        logic [TIME_W-1:0] cnt;
        logic [TIME_W-1:0] run_width;
        logic [TIME_W-1:0] run_gap;
        logic [CNT_W-1:0]  left;
    } chan_s_t;

    chan_s_t s_d, s_q;
    logic    hit;
    logic    start;

    always_comb begin
        hit   = |(src_rise_i & cfg_i.src_sel);
        start = (s_q.st == ST_IDLE) && hit && inhibit_n_i && (cfg_i.width != '0);
        s_d   = s_q;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st        = ST_WAIT;
                    s_d.cnt       = (cfg_i.delay == '0) ? ONE_T : cfg_i.delay;
                    s_d.left      = (cfg_i.reps == '0) ? ONE_C : cfg_i.reps;
                    s_d.run_width = cfg_i.width;
                    s_d.run_gap   = (cfg_i.period > cfg_i.width) ?
                                    (cfg_i.period - cfg_i.width) : ONE_T;
                end
            end
            ST_WAIT: begin
                if (tick_i) begin
                    if (s_q.cnt <= ONE_T) begin
                        s_d.st  = ST_HIGH;
                        s_d.cnt = s_q.run_width;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE_T;
                    end
                end
            end
            ST_HIGH: begin
                if (tick_i) begin
                    if (s_q.cnt <= ONE_T) begin
                        if (s_q.left <= ONE_C) begin
                            s_d.st   = ST_IDLE;
                            s_d.left = '0;
                        end else begin
                            s_d.st   = ST_LOW;
                            s_d.left = s_q.left - ONE_C;
                            s_d.cnt  = s_q.run_gap;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - ONE_T;
                    end
                end
            end
            ST_LOW: begin
                if (tick_i) begin
                    if (s_q.cnt <= ONE_T) begin
                        s_d.st  = ST_HIGH;
                        s_d.cnt = s_q.run_width;
                    end else begin
                        s_d.cnt = s_q.cnt - ONE_T;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = (s_q.st == ST_HIGH);

    // R7
    edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(pulse_o) || $fell(pulse_o)) |-> $past(tick_i));

    // R10
    no_start_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE && !inhibit_n_i) |=> (s_q.st == ST_IDLE));

    // R11
    run_cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |=> ((s_q.st == ST_IDLE) ||
                                 ($stable(s_q.run_width) && $stable(s_q.run_gap))));

    // R8
    left_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE) |-> (s_q.left != '0));

endmodule

// File: rtl/pulse_train_bank.sv
module pulse_train_bank import dpb_pkg::*; #(
    parameter int NUM_CH     = 8,
    parameter int FAST_DIV   = 100,
    parameter int SLOW_RATIO = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_slow,
    input  logic              inhibit_n,
    input  logic [NSRC-1:0]   trig_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [NUM_CH-1:0] pulse_out
);

    typedef struct packed {
        logic [NSRC-1:0] src_prev;
    } top_s_t;

    top_s_t               s_d, s_q;
    logic [NSRC-1:0]      src_rise;
    logic                 tick;
    ch_cfg_t [NUM_CH-1:0] cfg;

    always_comb begin
        s_d          = s_q;
        s_d.src_prev = trig_src;
        src_rise     = trig_src & ~s_q.src_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    dpb_tick #(
        .FAST_DIV   (FAST_DIV),
        .SLOW_RATIO (SLOW_RATIO)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .slow_i (base_slow),
        .tick_o (tick)
    );

    dpb_regfile #(
        .NUM_CH (NUM_CH)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .cfg_o     (cfg)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        dpb_channel u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_i      (tick),
            .inhibit_n_i (inhibit_n),
            .src_rise_i  (src_rise),
            .cfg_i       (cfg[i]),
            .pulse_o     (pulse_out[i])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pulse_out == '0));

endmodule

// File: tb/tb_pulse_train_bank.sv
module tb_pulse_train_bank;

    localparam int CLK_PERIOD = 10;
    localparam int FDIV       = 4;
    localparam int SRATIO     = 10;
    localparam int NV         = 7;

    localparam int V_CH [NV] = '{0, 7, 3, 5, 1, 6, 2};
    localparam int V_SRC[NV] = '{0, 7, 5, 2, 1, 4, 3};
    localparam int V_D  [NV] = '{3, 1, 0, 2, 2, 1, 4};
    localparam int V_W  [NV] = '{2, 1, 3, 2, 4, 0, 1};
    localparam int V_P  [NV] = '{5, 2, 4, 6, 3, 3, 3};
    localparam int V_R  [NV] = '{3, 4, 0, 2, 2, 2, 1};
    localparam int V_S  [NV] = '{0, 0, 0, 1, 0, 0, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_slow = 1'b0;
    logic        inhibit_n = 1'b1;
    logic [7:0]  trig_src = '0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pulse_out;

    int errors = 0;
    int total  = 0;
    bit done   = 1'b0;

    int m_rises, m_first, m_w, m_sp, m_other;

    pulse_train_bank #(
        .NUM_CH     (8),
        .FAST_DIV   (FDIV),
        .SLOW_RATIO (SRATIO)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_slow (base_slow),
        .inhibit_n (inhibit_n),
        .trig_src  (trig_src),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .pulse_out (pulse_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = 16'(data);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic prog(input int ch, input int src, input int d, input int w,
                        input int p, input int r);
        wr(0, ch);
        wr(1, d);  wr(2, 0);
        wr(3, w);  wr(4, 0);
        wr(5, p);  wr(6, 0);
        wr(7, r);
        wr(8, 1 << src);
    endtask

    // Fires source src at k=0, then samples win cycles at the falling edge.
    task automatic run(input int ch, input int src, input int win,
                       input int retrig_at, input int inh_at,
                       input int wr_at, input int wr_val);
        bit prev = 1'b0;
        bit cur;
        m_rises = 0; m_first = 0; m_w = 0; m_sp = 0; m_other = 0;
        trig_src      = '0;
        trig_src[src] = 1'b1;
        for (int k = 1; k <= win; k++) begin
            @(posedge clk);
            @(negedge clk);
            trig_src = '0;
            wr_en    = 1'b0;
            if (k == retrig_at) trig_src[src] = 1'b1;
            if (k == inh_at) inhibit_n = 1'b0;
            if (k == wr_at) begin
                wr_en   = 1'b1;
                wr_addr = 4'd3;
                wr_data = 16'(wr_val);
            end
            cur = pulse_out[ch];
            if (cur && !prev) begin
                m_rises++;
                if (m_rises == 1) m_first = k;
                if (m_rises == 2) m_sp = k - m_first;
            end
            if (cur && m_rises == 1) m_w++;
            if ((pulse_out & ~(8'(1) << ch)) != '0) m_other = 1;
            prev = cur;
        end
        trig_src = '0;
        wr_en    = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            total++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, total);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs low while in reset and after release
        chk(pulse_out == '0, "R1", "outputs in reset", int'(pulse_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(pulse_out == '0, "R1", "outputs after reset", int'(pulse_out), 0);

        // Table of settings: R2 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int t, dd, np, sp, win;
            t   = V_S[v] ? FDIV * SRATIO : FDIV;
            dd  = (V_D[v] == 0) ? 1 : V_D[v];
            np  = (V_W[v] == 0) ? 0 : ((V_R[v] == 0) ? 1 : V_R[v]);
            sp  = (V_P[v] > V_W[v]) ? V_P[v] : V_W[v] + 1;
            win = (dd + np * sp + 4) * t + 8;
            @(negedge clk);
            base_slow = V_S[v][0];
            repeat (3) @(negedge clk);
            prog(V_CH[v], V_SRC[v], V_D[v], V_W[v], V_P[v], V_R[v]);
            run(V_CH[v], V_SRC[v], win, 0, 0, 0, 0);
            chk(m_rises == np, "R8", $sformatf("vec%0d pulse count", v), m_rises, np);
            chk(m_other == 0, "R2", $sformatf("vec%0d other outputs quiet", v), m_other, 0);
            if (np > 0) begin
                chk(m_w == V_W[v] * t, "R7", $sformatf("vec%0d width cycles", v),
                    m_w, V_W[v] * t);
                chk(m_first >= (dd - 1) * t + 1 && m_first <= dd * t + 2, "R6",
                    $sformatf("vec%0d first rise", v), m_first, dd * t);
            end
            if (np > 1) begin
                chk(m_sp == sp * t, "R8", $sformatf("vec%0d spacing", v), m_sp, sp * t);
            end
            if (V_S[v] != 0) begin
                chk(m_w == V_W[v] * FDIV * SRATIO, "R4",
                    $sformatf("vec%0d slow tick length", v), m_w, V_W[v] * FDIV * SRATIO);
            end
        end

        @(negedge clk);
        base_slow = 1'b0;
        repeat (3) @(negedge clk);

        // R9: second trigger during a running train is ignored
        run(0, 0, 92, 10, 0, 0, 0);
        chk(m_rises == 3, "R9", "retrigger pulse count", m_rises, 3);
        chk(m_sp == 20, "R9", "retrigger spacing", m_sp, 20);

        // R10: inhibit blocks a start
        @(negedge clk);
        inhibit_n = 1'b0;
        run(0, 0, 92, 0, 0, 0, 0);
        chk(m_rises == 0, "R10", "start under inhibit", m_rises, 0);
        inhibit_n = 1'b1;

        // R10: inhibit during a running train lets it finish
        run(0, 0, 92, 0, 4, 0, 0);
        chk(m_rises == 3, "R10", "inhibit mid-train count", m_rises, 3);
        @(negedge clk);
        inhibit_n = 1'b1;

        // R11: width rewrite during a train applies only at the next start
        wr(0, 0);
        run(0, 0, 92, 0, 0, 6, 1);
        chk(m_w == 8, "R11", "width unchanged in running train", m_w, 8);
        chk(m_rises == 3, "R11", "count unchanged in running train", m_rises, 3);
        run(0, 0, 92, 0, 0, 0, 0);
        chk(m_w == 4, "R11", "new width at next start", m_w, 4);
        chk(m_sp == 20, "R11", "spacing with new width", m_sp, 20);

        // R5: unselected source does not start a channel
        prog(4, 6, 1, 1, 2, 1);
        run(0, 0, 92, 0, 0, 0, 0);
        chk(m_other == 0, "R5", "channel 4 quiet on unselected source", m_other, 0);
        run(4, 6, 40, 0, 0, 0, 0);
        chk(m_rises == 1, "R5", "channel 4 fires on its source", m_rises, 1);

        // R3: delay high half lengthens the delay by 65536 ticks
        wr(0, 0);
        wr(2, 1);
        run(0, 0, 200, 0, 0, 0, 0);
        chk(m_rises == 0, "R3", "no pulse with delay high half set", m_rises, 0);

        // R1: reset in the middle of a train returns the channel to idle
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(pulse_out == '0, "R1", "outputs during mid-run reset", int'(pulse_out), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        prog(0, 0, 3, 2, 5, 3);
        run(0, 0, 92, 0, 0, 0, 0);
        chk(m_rises == 3, "R1", "channel restarts after reset", m_rises, 3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

endmodule